// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is a 16-bit up-counter that sits behind a byte-wide register bus. Software programs a clock-select code and a 4-bit waveform mode. The clock-select code sets the step rate. The mode sets the TOP value, which is the count at which the counter returns to zero. TOP can be the full 16-bit range, a fixed 8-, 9- or 10-bit limit, or the value held in the capture register. The counter, the compare register and the capture register are each 16 bits wide and are reached as a pair of bytes.

Two events are recorded in a flag register. The overflow event marks a wrap. The compare event marks a step onto the compare value. An interrupt request is raised when a flag is set, its mask bit is set, and the global enable input is high. The request stays asserted until an acknowledge pulse clears the flag being serviced. Software can also clear flags directly by writing a 1 to them.

Top module: `tmr16_unit`

## Requirements
- R1: With clock select 1 the count increases by exactly one on every clock. Clock-select codes 0, 6 and 7 hold the count unchanged.
- R2: Clock-select codes 2, 3, 4 and 5 make the count advance once every 8, 64, 256 and 1024 clocks respectively. The prescaler runs freely, so any window that is a whole number of divisor periods long yields exactly window/divisor steps.
- R3: Register map: 0 = control A, 1 = control B, 2/3 = count low/high, 4/5 = compare low/high, 6/7 = capture low/high, 8 = flags, 9 = mask. Each 16-bit register has its low byte at the lower address. A write to one byte changes only that byte, and every register reads back what was written.
- R4: Mode bits 1:0 are control A bits 1:0. Mode bits 3:2 are control B bits 4:3. Clock select is control B bits 2:0. All other control bits read as 0.
- R5: In mode 0 the counter steps from 0xFFFF to 0 and sets the overflow flag, which is flags bit 0.
- R6: When a step lands on the compare value, the compare flag (flags bit 1) is set. With its mask bit clear, no request is raised.
- R7: Modes 5, 6 and 7 use TOP values of 0x00FF, 0x01FF and 0x03FF. The step from TOP goes to 0 and sets the overflow flag.
- R8: Modes 12 and 14 use the capture register as TOP, and the step from TOP goes to 0. Mode 12 does not set the overflow flag on this wrap; mode 14 does. Every other mode code behaves as mode 0.
- R9: A request is raised only when the global enable input is high and some flag is set together with its mask bit (mask bit 0 for overflow, bit 1 for compare). The irq_id output gives the serviced flag's bit position. Compare (1) wins over overflow (0).
- R10: The request holds until a one-cycle acknowledge. The acknowledge clears only the flag named by irq_id.
- R11: Writing to the flag register clears every bit written as 1. Bits written as 0 are left unchanged.
- R12: A bus write to a count byte in a step cycle takes priority over the increment. The compare check in that cycle still uses the value the step would have produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte of the addressed register (combinational) |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge pulse for the current request |
| irq_req | output | 1 | Interrupt request |
| irq_id | output | 1 | Flag bit being requested: 1 compare, 0 overflow |

## Verification
The hardest situation to reach is a count-byte write that lands in exactly the same cycle as a step. The stimulus reaches it with a fixed write task that takes two clocks. It starts the counter from a known value and issues the write immediately afterwards. The count at the write edge is then known exactly, so the compare register can be set to the stepped value that the write overrides. Having both flags pending at once is arranged by placing the compare value at 0 and wrapping from 0xFFFF, so that one step raises both flags.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 16;
    localparam int CS_W   = 3;
    localparam int MODE_W = 4;
    localparam int PRE_W  = 10;
    localparam int N_SRC  = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTLA  = 4'd0,
        A_CTLB  = 4'd1,
        A_CNT_L = 4'd2,
        A_CNT_H = 4'd3,
        A_CMP_L = 4'd4,
        A_CMP_H = 4'd5,
        A_CAP_L = 4'd6,
        A_CAP_H = 4'd7,
        A_FLAG  = 4'd8,
        A_MASK  = 4'd9
    } reg_addr_e;

    localparam int FLG_OVF = 0;
    localparam int FLG_CMP = 1;

    typedef struct packed {
        logic [CNT_W-1:0] top;
        logic             ovf_at_top;
    } top_sel_t;

    // Prescaler tap widths for the divided clock-select codes.
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    function automatic top_sel_t pick_top(input logic [MODE_W-1:0] mode,
                                          input logic [CNT_W-1:0]  cap);
        top_sel_t r;
        case (mode)
            4'd5:    r = '{top: 16'h00FF, ovf_at_top: 1'b1};
            4'd6:    r = '{top: 16'h01FF, ovf_at_top: 1'b1};
            4'd7:    r = '{top: 16'h03FF, ovf_at_top: 1'b1};
            4'd12:   r = '{top: cap,      ovf_at_top: 1'b0};
            4'd14:   r = '{top: cap,      ovf_at_top: 1'b1};
            default: r = '{top: 16'hFFFF, ovf_at_top: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
    import tmr16_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int SW = CS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] cs_i,
    output logic          step_o
);

    localparam int N_TAP = 4;

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_st_t;

    pre_st_t          s_q, s_d;
    logic [N_TAP-1:0] tap_hit;

    generate
        for (genvar gi = 0; gi < N_TAP; gi++) begin : g_tap
            localparam int SH = tap_shift(gi);
            assign tap_hit[gi] = &s_q.pre[SH-1:0];
        end
    endgenerate

    always_comb begin
        s_d     = s_q;
        s_d.pre = s_q.pre + 1'b1;
        case (cs_i)
            SW'(1):  step_o = 1'b1;
            SW'(2):  step_o = tap_hit[0];
            SW'(3):  step_o = tap_hit[1];
            SW'(4):  step_o = tap_hit[2];
            SW'(5):  step_o = tap_hit[3];
            default: step_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_STOPPED_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i == SW'(0) || cs_i > SW'(5)) |-> !step_o); // R1
    AST_DIV8_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i == SW'(2) && step_o) ##1 (cs_i == SW'(2)) |-> !step_o); // R2

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
    import tmr16_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [CW-1:0] top_i,
    input  logic          ovf_at_top_i,
    input  logic [CW-1:0] cmp_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [BW-1:0] wdata_i,
    output logic [CW-1:0] count_o,
    output logic          ovf_evt_o,
    output logic          cmp_evt_o
);

    localparam int HI_W = CW - BW;

    typedef struct packed {
        logic [CW-1:0] count;
    } cnt_st_t;

    cnt_st_t       s_q, s_d;
    logic [CW-1:0] stepped;
    logic          at_top;

    always_comb begin
        s_d       = s_q;
        at_top    = (s_q.count == top_i);
        stepped   = at_top ? '0 : s_q.count + 1'b1;
        ovf_evt_o = step_i && ((&s_q.count) || (at_top && ovf_at_top_i));
        cmp_evt_o = step_i && (stepped == cmp_i);
        if (step_i) s_d.count = stepped;
        if (wr_lo_i) s_d.count = {s_q.count[CW-1:BW], wdata_i};
        if (wr_hi_i) s_d.count = {wdata_i[HI_W-1:0], s_q.count[BW-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.count;

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_lo_i && !wr_hi_i && count_o != top_i)
        |=> (count_o == CW'($past(count_o) + 1'b1))); // R1
    AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_lo_i && !wr_hi_i && count_o == top_i) |=> (count_o == '0)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !wr_lo_i && !wr_hi_i) |=> $stable(count_o)); // R1
    AST_WRITE_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wr_hi_i) |=> (count_o[BW-1:0] == $past(wdata_i))); // R12

endmodule

// File: rtl/tmr16_irq.sv
module tmr16_irq
    import tmr16_pkg::*;
#(
    parameter int NS   = N_SRC,
    parameter int ID_W = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NS-1:0]   evt_i,
    input  logic            wr_flag_i,
    input  logic            wr_mask_i,
    input  logic [NS-1:0]   wdata_i,
    input  logic            gie_i,
    input  logic            ack_i,
    output logic [NS-1:0]   flags_o,
    output logic [NS-1:0]   mask_o,
    output logic            irq_req_o,
    output logic [ID_W-1:0] irq_id_o
);

    typedef struct packed {
        logic [NS-1:0] flags;
        logic [NS-1:0] mask;
    } irq_st_t;

    irq_st_t       s_q, s_d;
    logic [NS-1:0] pend;
    logic [NS-1:0] clr;

    always_comb begin
        s_d       = s_q;
        pend      = gie_i ? (s_q.flags & s_q.mask) : '0;
        irq_req_o = |pend;
        irq_id_o  = '0;
        for (int i = 0; i < NS; i++) begin
            if (pend[i]) irq_id_o = ID_W'(i);
        end
        clr = wr_flag_i ? wdata_i : '0;
        if (ack_i && irq_req_o) clr[irq_id_o] = 1'b1;
        s_d.flags = (s_q.flags & ~clr) | evt_i;
        if (wr_mask_i) s_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o = s_q.flags;
    assign mask_o  = s_q.mask;

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> gie_i); // R9
    AST_ID_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (flags_o[irq_id_o] && mask_o[irq_id_o])); // R9
    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_req_o && !evt_i[irq_id_o]) |=> !flags_o[$past(irq_id_o)]); // R10
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_flag_i && !ack_i && evt_i == '0) |=> $stable(flags_o)); // R11

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              gie,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic              irq_id
);

    typedef struct packed {
        logic [1:0]       wgm_lo;
        logic [1:0]       wgm_hi;
        logic [CS_W-1:0]  cs;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] cap;
    } cfg_t;

    cfg_t              c_q, c_d;
    logic [MODE_W-1:0] mode;
    top_sel_t          tsel;
    logic              step;
    logic [CNT_W-1:0]  count;
    logic              ovf_evt, cmp_evt;
    logic [N_SRC-1:0]  flags, mask;

    function automatic logic hit(input reg_addr_e a);
        return bus_wr && (bus_addr == a);
    endfunction

    always_comb begin
        c_d = c_q;
        if (hit(A_CTLA)) c_d.wgm_lo = bus_wdata[1:0];
        if (hit(A_CTLB)) begin
            c_d.wgm_hi = bus_wdata[4:3];
            c_d.cs     = bus_wdata[CS_W-1:0];
        end
        if (hit(A_CMP_L)) c_d.cmp[7:0]  = bus_wdata;
        if (hit(A_CMP_H)) c_d.cmp[15:8] = bus_wdata;
        if (hit(A_CAP_L)) c_d.cap[7:0]  = bus_wdata;
        if (hit(A_CAP_H)) c_d.cap[15:8] = bus_wdata;
        mode = {c_q.wgm_hi, c_q.wgm_lo};
        tsel = pick_top(mode, c_q.cap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTLA:  bus_rdata = {6'b0, c_q.wgm_lo};
            A_CTLB:  bus_rdata = {3'b0, c_q.wgm_hi, c_q.cs};
            A_CNT_L: bus_rdata = count[7:0];
            A_CNT_H: bus_rdata = count[15:8];
            A_CMP_L: bus_rdata = c_q.cmp[7:0];
            A_CMP_H: bus_rdata = c_q.cmp[15:8];
            A_CAP_L: bus_rdata = c_q.cap[7:0];
            A_CAP_H: bus_rdata = c_q.cap[15:8];
            A_FLAG:  bus_rdata = BYTE_W'(flags);
            A_MASK:  bus_rdata = BYTE_W'(mask);
            default: bus_rdata = '0;
        endcase
    end

    tmr16_prescale #(.PW(PRE_W), .SW(CS_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_i   (c_q.cs),
        .step_o (step)
    );

    tmr16_count #(.CW(CNT_W), .BW(BYTE_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step),
        .top_i        (tsel.top),
        .ovf_at_top_i (tsel.ovf_at_top),
        .cmp_i        (c_q.cmp),
        .wr_lo_i      (hit(A_CNT_L)),
        .wr_hi_i      (hit(A_CNT_H)),
        .wdata_i      (bus_wdata),
        .count_o      (count),
        .ovf_evt_o    (ovf_evt),
        .cmp_evt_o    (cmp_evt)
    );

    tmr16_irq #(.NS(N_SRC), .ID_W(1)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     ({cmp_evt, ovf_evt}),
        .wr_flag_i (hit(A_FLAG)),
        .wr_mask_i (hit(A_MASK)),
        .wdata_i   (bus_wdata[N_SRC-1:0]),
        .gie_i     (gie),
        .ack_i     (irq_ack),
        .flags_o   (flags),
        .mask_o    (mask),
        .irq_req_o (irq_req),
        .irq_id_o  (irq_id)
    );

    AST_MODE12_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd12 && step && count == c_q.cap && !(&count) && !cmp_evt
         && !bus_wr && !irq_ack) |=> $stable(flags)); // R8

endmodule

// File: tb/tmr16_unit_bench.sv
`timescale 1ns/100ps
module tmr16_unit_bench;

    localparam real CLK_PERIOD = 10.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic       irq_id;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    tmr16_unit u_tmr16_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gie       (gie),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req),
        .irq_id    (irq_id)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #0.1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a + 4'd1, v[15:8]);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #0.1;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #0.1;
    endtask

    // Stop the counter, select a mode, load the count and clear flags and mask.
    task automatic setup(input logic [3:0] mode, input logic [15:0] cnt);
        wr(4'd1, {3'b0, mode[3:2], 3'd0});
        wr(4'd0, {6'b0, mode[1:0]});
        wr16(4'd2, cnt);
        wr(4'd9, 8'h00);
        wr(4'd8, 8'hFF);
    endtask

    task automatic start(input logic [3:0] mode, input logic [2:0] cs);
        wr(4'd1, {3'b0, mode[3:2], cs});
    endtask

    task automatic t_reset();
        logic [7:0] b;
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), b);
            chk("R3 reset value", {8'h0, b}, 16'h0);
        end
        chk("R9 reset irq_req", {15'h0, irq_req}, 16'h0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        logic [7:0]  b;
        wr16(4'd4, 16'hA55A);
        wr16(4'd6, 16'h1234);
        rd16(4'd4, v); chk("R3 compare readback", v, 16'hA55A);
        rd16(4'd6, v); chk("R3 capture readback", v, 16'h1234);
        wr(4'd7, 8'hBE);
        rd16(4'd6, v); chk("R3 high byte only", v, 16'hBE34);
        wr(4'd0, 8'hFF);
        rd(4'd0, b); chk("R4 control A bits", {8'h0, b}, 16'h0003);
        wr(4'd1, 8'hE0 | 8'h1E);
        rd(4'd1, b); chk("R4 control B bits", {8'h0, b}, 16'h001E);
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h00);
    endtask

    task automatic t_rate();
        logic [15:0] v0, v1;
        setup(4'd0, 16'h2233);
        start(4'd0, 3'd1);
        tick(1);
        rd16(4'd2, v0); chk("R1 first step", v0, 16'h2234);
        tick(5);
        rd16(4'd2, v1); chk("R1 one per clock", v1, 16'h2239);
        start(4'd0, 3'd0);
        rd16(4'd2, v0); tick(7);
        rd16(4'd2, v1); chk("R1 stopped at cs0", v1, v0);
        start(4'd0, 3'd6);
        rd16(4'd2, v0); tick(9);
        rd16(4'd2, v1); chk("R1 stopped at cs6", v1, v0);
        start(4'd0, 3'd2);
        rd16(4'd2, v0); tick(80);
        rd16(4'd2, v1); chk("R2 divide by 8", v1 - v0, 16'd10);
        start(4'd0, 3'd3);
        rd16(4'd2, v0); tick(256);
        rd16(4'd2, v1); chk("R2 divide by 64", v1 - v0, 16'd4);
        start(4'd0, 3'd5);
        rd16(4'd2, v0); tick(3072);
        rd16(4'd2, v1); chk("R2 divide by 1024", v1 - v0, 16'd3);
        start(4'd0, 3'd0);
    endtask

    task automatic t_normal_wrap();
        logic [15:0] v;
        logic [7:0]  f;
        setup(4'd0, 16'hFFFD);
        wr16(4'd4, 16'h8000);
        start(4'd0, 3'd1);
        tick(2);
        rd(4'd8, f); chk("R5 no flag before wrap", {8'h0, f}, 16'h0);
        tick(1);
        rd16(4'd2, v); chk("R5 wrap to zero", v, 16'h0000);
        rd(4'd8, f); chk("R5 overflow flag", {8'h0, f}, 16'h0001);
        start(4'd0, 3'd0);
    endtask

    task automatic t_compare();
        logic [7:0] f;
        setup(4'd0, 16'h10EE);
        wr16(4'd4, 16'h10EF);
        gie = 1'b1;
        start(4'd0, 3'd1);
        tick(1);
        rd(4'd8, f); chk("R6 compare flag", {8'h0, f}, 16'h0002);
        chk("R6 masked no request", {15'h0, irq_req}, 16'h0);
        start(4'd0, 3'd0);
        gie = 1'b0;
    endtask

    task automatic t_fixed_top(input logic [3:0] mode, input logic [15:0] top, input string tag);
        logic [15:0] v;
        logic [7:0]  f;
        setup(mode, top - 16'd1);
        wr16(4'd4, 16'h8000);
        start(mode, 3'd1);
        tick(1);
        rd16(4'd2, v); chk({tag, " reaches top"}, v, top);
        tick(1);
        rd16(4'd2, v); chk({tag, " wraps to zero"}, v, 16'h0);
        rd(4'd8, f); chk({tag, " overflow flag"}, {8'h0, f}, 16'h0001);
        start(mode, 3'd0);
    endtask

    task automatic t_capture_top(input logic [3:0] mode, input logic [7:0] exp_f, input string tag);
        logic [15:0] v;
        logic [7:0]  f;
        setup(mode, 16'h500F);
        wr16(4'd6, 16'h5010);
        wr16(4'd4, 16'h8000);
        start(mode, 3'd1);
        tick(1);
        rd16(4'd2, v); chk({tag, " at capture top"}, v, 16'h5010);
        tick(1);
        rd16(4'd2, v); chk({tag, " wraps to zero"}, v, 16'h0);
        rd(4'd8, f); chk({tag, " flags after wrap"}, {8'h0, f}, {8'h0, exp_f});
        start(mode, 3'd0);
    endtask

    task automatic both_flags();
        setup(4'd0, 16'hFFFE);
        wr16(4'd4, 16'h0000);
        start(4'd0, 3'd1);
        tick(2);
        start(4'd0, 3'd0);
    endtask

    task automatic t_irq();
        logic [7:0] f;
        both_flags();
        rd(4'd8, f); chk("R9 both flags set", {8'h0, f}, 16'h0003);
        gie = 1'b1; #0.1;
        chk("R9 no request with mask clear", {15'h0, irq_req}, 16'h0);
        gie = 1'b0;
        wr(4'd9, 8'h03);
        chk("R9 no request with gie low", {15'h0, irq_req}, 16'h0);
        gie = 1'b1; #0.1;
        chk("R9 request raised", {15'h0, irq_req}, 16'h1);
        chk("R9 compare wins", {15'h0, irq_id}, 16'h1);
        ack_pulse();
        rd(4'd8, f); chk("R10 ack clears compare only", {8'h0, f}, 16'h0001);
        chk("R10 overflow now requested", {15'h0, irq_id}, 16'h0);
        tick(4);
        chk("R10 request held until ack", {15'h0, irq_req}, 16'h1);
        ack_pulse();
        rd(4'd8, f); chk("R10 ack clears overflow", {8'h0, f}, 16'h0);
        chk("R10 request dropped", {15'h0, irq_req}, 16'h0);
        gie = 1'b0;
    endtask

    task automatic t_w1c();
        logic [7:0] f;
        both_flags();
        wr(4'd8, 8'h00);
        rd(4'd8, f); chk("R11 zero write keeps flags", {8'h0, f}, 16'h0003);
        wr(4'd8, 8'h02);
        rd(4'd8, f); chk("R11 clear compare bit", {8'h0, f}, 16'h0001);
        wr(4'd8, 8'h01);
        rd(4'd8, f); chk("R11 clear overflow bit", {8'h0, f}, 16'h0);
    endtask

    task automatic t_write_priority();
        logic [15:0] v;
        logic [7:0]  f;
        setup(4'd0, 16'h1234);
        wr16(4'd4, 16'h1236);
        start(4'd0, 3'd1);
        wr(4'd2, 8'h80);
        rd16(4'd2, v); chk("R12 write beats step", v, 16'h1280);
        rd(4'd8, f); chk("R12 compare on stepped value", {8'h0, f}, 16'h0002);
        start(4'd0, 3'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        t_reset();
        t_regs();
        t_rate();
        t_normal_wrap();
        t_compare();
        t_fixed_top(4'd7, 16'h03FF, "R7 mode7");
        t_fixed_top(4'd5, 16'h00FF, "R7 mode5");
        t_fixed_top(4'd6, 16'h01FF, "R7 mode6");
        t_capture_top(4'd12, 8'h00, "R8 mode12");
        t_capture_top(4'd14, 8'h01, "R8 mode14");
        t_irq();
        t_w1c();
        t_write_priority();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule